// File: doc/BRIEF.md
# Serial byte-memory slave with write guarding

This block is the serial front end of a 2048 x 8 nonvolatile byte store. A host drives a four-wire serial link in clock mode 0 and sends an eight-bit command. Some commands take a two-byte start address and then move any number of data bytes. The block turns these into single-cycle read and write strobes on a synchronous byte port to the storage array. It steps the address after every byte and wraps at the top of the array. Writes go straight to the array with no staging buffer and no busy period.

Several guards must agree before a write takes effect. These are a write-arm latch, a two-bit lock level that protects a top slice of the array, and a pin-guard bit. When the pin-guard bit is set, an active-low pin can freeze the status byte. An active-low pause input stops a transfer in mid-flight, and the transfer resumes where it stopped. All serial pins are oversampled by the system clock `clk`, so the serial clock must stay at least three `clk` cycles in each phase.

Top module: `spi_fram_slave`

## Requirements
- R1: A falling `spi_sel_n` starts a command and a rising one ends it. `spi_miso_oe` is 1 only while `spi_sel_n` is low and `pause_n` is high. After reset it is 0 and no memory strobe is active.
- R2: Bits are sampled on rising `spi_clk` and sent MSB first. The command codes are: arm 06h, disarm 04h, status read 05h, status write 01h, read 03h, write 02h.
- R3: Read (03h) takes a high and a low address byte, and only the low 11 bits are used. `mem_re` pulses one `clk` after the last address bit. `mem_rdata` is expected one `clk` after `mem_re`. Each data bit appears on `spi_miso` at the falling `spi_clk` edge before the rising edge where the host samples it.
- R4: During reads and writes the address rises by one for each further byte and wraps from 7FFh to 000h.
- R5: Write (02h) commits each data byte as a one-cycle `mem_we` pulse, one `clk` after the byte's eighth rising edge. There is no limit on the byte count.
- R6: The arm command sets the write-arm latch. While the latch is clear, no array write and no status write has any effect. The latch clears when a write, status write or disarm command ends at the rising `spi_sel_n`.
- R7: With the latch set, lock level 00 protects nothing, 01 protects 600h–7FFh, 10 protects 400h–7FFh and 11 protects the whole array. Bytes aimed at a protected address are dropped, but the address still advances.
- R8: The status byte is laid out as: bit 7 pin-guard, bits 3:2 lock level, bit 1 write-arm latch, all other bits 0. Status read repeats it for as long as clocks continue. Status write loads bits 7, 3 and 2.
- R9: A status write is refused when the pin-guard bit is 1 and `lock_pin_n` is 0. With the pin-guard bit at 0, `lock_pin_n` has no effect.
- R10: `pause_n` falling while `spi_clk` is low freezes the transfer, and `pause_n` rising while `spi_clk` is low resumes it. `spi_clk` edges during the pause change no state.
- R11: An unknown command code makes the rest of that command ignored until `spi_sel_n` rises. `spi_mosi` is ignored during read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_clk | input | 1 | Serial clock from the host |
| spi_sel_n | input | 1 | Active-low select that frames a command |
| spi_mosi | input | 1 | Serial data into the block |
| lock_pin_n | input | 1 | Active-low status-freeze pin, used when pin-guard is set |
| pause_n | input | 1 | Active-low transfer pause |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso`; pad floats when 0 |
| mem_addr | output | AW | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_re | output | 1 | One-cycle array read strobe |
| mem_rdata | input | 8 | Array read data, valid one clk after `mem_re` |

## Verification
Each serial edge takes effect at the first `clk` edge that sees the new pin level. A write strobe follows one `clk` after the eighth rising edge of a byte. Read data is requested one `clk` after the last address bit, is held one `clk` later, and reaches `spi_miso` at the next falling serial edge. The bench samples `spi_miso` four `clk` cycles after each fall, just before it raises the serial clock. Its scoreboard checks write strobes on the falling `clk` edge while they are high, against the queue of writes the driver predicted.

// File: rtl/spi_fram_pkg.sv
package spi_fram_pkg;

  localparam logic [7:0] OP_ARM      = 8'h06;
  localparam logic [7:0] OP_DISARM   = 8'h04;
  localparam logic [7:0] OP_STAT_RD  = 8'h05;
  localparam logic [7:0] OP_STAT_WR  = 8'h01;
  localparam logic [7:0] OP_READ     = 8'h03;
  localparam logic [7:0] OP_WRITE    = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_RDATA, PH_WDATA, PH_STAT_RD, PH_STAT_WR, PH_SKIP
  } phase_t;

  // top2 holds the two most significant address bits
  function automatic logic region_locked(input logic [1:0] lvl, input logic [1:0] top2);
    case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic guard, input logic [1:0] lvl,
                                             input logic arm);
    return {guard, 3'b000, lvl, arm, 1'b0};
  endfunction

endpackage

// File: rtl/spi_fram_pins.sv
module spi_fram_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_clk,
  input  logic spi_sel_n,
  input  logic pause_n,
  output logic bit_rise,
  output logic bit_fall,
  output logic sel_start,
  output logic sel_end,
  output logic held
);
  logic clk_q, sel_q, pause_q, held_q, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q   <= 1'b0;
      sel_q   <= 1'b1;
      pause_q <= 1'b1;
      held_q  <= 1'b0;
    end else begin
      clk_q   <= spi_clk;
      sel_q   <= spi_sel_n;
      pause_q <= pause_n;
      if (spi_sel_n)
        held_q <= 1'b0;
      else if (!spi_clk && (pause_q != pause_n))
        held_q <= !pause_n;
    end
  end

  assign active    = !spi_sel_n && !held_q;
  assign bit_rise  = active && spi_clk && !clk_q;
  assign bit_fall  = active && !spi_clk && clk_q;
  assign sel_start = sel_q && !spi_sel_n;
  assign sel_end   = !sel_q && spi_sel_n;
  assign held      = held_q;
endmodule

// File: rtl/spi_fram_status.sv
module spi_fram_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_set,
  input  logic       arm_clr,
  input  logic       stat_wr,
  input  logic       new_guard,
  input  logic [1:0] new_lvl,
  input  logic       lock_pin_n,
  output logic       arm,
  output logic       guard,
  output logic [1:0] lvl,
  output logic       stat_ok,
  output logic [7:0] stat_byte
);
  import spi_fram_pkg::*;

  assign stat_ok   = arm && !(guard && !lock_pin_n);
  assign stat_byte = pack_status(guard, lvl, arm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm   <= 1'b0;
      guard <= 1'b0;
      lvl   <= 2'b00;
    end else begin
      if (arm_clr)      arm <= 1'b0;
      else if (arm_set) arm <= 1'b1;
      if (stat_wr && stat_ok) begin
        guard <= new_guard;
        lvl   <= new_lvl;
      end
    end
  end
endmodule

// File: rtl/spi_fram_seq.sv
module spi_fram_seq #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_rise,
  input  logic          bit_fall,
  input  logic          sel_start,
  input  logic          sel_end,
  input  logic          spi_mosi,
  input  logic          arm,
  input  logic [1:0]    lvl,
  input  logic [7:0]    stat_byte,
  input  logic [7:0]    mem_rdata,
  output logic          miso_q,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          arm_set,
  output logic          arm_clr,
  output logic          stat_wr,
  output logic          new_guard,
  output logic [1:0]    new_lvl,
  output logic          byte_done,
  output logic [2:0]    bit_cnt
);
  import spi_fram_pkg::*;
  localparam int HI_W = AW - 8;

  phase_t        phase;
  logic [6:0]    shreg;
  logic [7:0]    rx_byte, tx_buf;
  logic [AW-1:0] ptr;
  logic          is_read, hi_seen, clr_pend, rd_pend, wr_ok;

  assign rx_byte   = {shreg, spi_mosi};
  assign byte_done = bit_rise && (bit_cnt == 3'd7);
  assign arm_set   = byte_done && (phase == PH_CMD) && (rx_byte == OP_ARM);
  assign arm_clr   = sel_end && clr_pend;
  assign stat_wr   = byte_done && (phase == PH_STAT_WR);
  assign new_guard = rx_byte[7];
  assign new_lvl   = rx_byte[3:2];
  assign wr_ok     = arm && !region_locked(lvl, ptr[AW-1:AW-2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_SKIP;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx_buf    <= '0;
      ptr       <= '0;
      is_read   <= 1'b0;
      hi_seen   <= 1'b0;
      clr_pend  <= 1'b0;
      rd_pend   <= 1'b0;
      miso_q    <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_re  <= 1'b0;
      mem_we  <= 1'b0;
      rd_pend <= mem_re;
      if (rd_pend) tx_buf <= mem_rdata;
      if (sel_start) begin
        phase    <= PH_CMD;
        bit_cnt  <= '0;
        hi_seen  <= 1'b0;
        clr_pend <= 1'b0;
      end else if (sel_end) begin
        phase <= PH_SKIP;
      end else begin
        if (bit_rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          shreg   <= {shreg[5:0], spi_mosi};
        end
        if (byte_done) begin
          case (phase)
            PH_CMD: begin
              case (rx_byte)
                OP_READ:    begin phase <= PH_ADDR; is_read <= 1'b1; end
                OP_WRITE:   begin phase <= PH_ADDR; is_read <= 1'b0; clr_pend <= 1'b1; end
                OP_STAT_RD: begin phase <= PH_STAT_RD; tx_buf <= stat_byte; end
                OP_STAT_WR: begin phase <= PH_STAT_WR; clr_pend <= 1'b1; end
                OP_DISARM:  begin phase <= PH_SKIP; clr_pend <= 1'b1; end
                default:    phase <= PH_SKIP;
              endcase
            end
            PH_ADDR: begin
              if (!hi_seen) begin
                hi_seen        <= 1'b1;
                ptr[AW-1:8]    <= rx_byte[HI_W-1:0];
              end else begin
                ptr[7:0] <= rx_byte;
                if (is_read) begin
                  mem_re   <= 1'b1;
                  mem_addr <= {ptr[AW-1:8], rx_byte};
                  phase    <= PH_RDATA;
                end else begin
                  phase <= PH_WDATA;
                end
              end
            end
            PH_RDATA: begin
              ptr      <= ptr + 1'b1;
              mem_re   <= 1'b1;
              mem_addr <= ptr + 1'b1;
            end
            PH_WDATA: begin
              mem_we    <= wr_ok;
              mem_addr  <= ptr;
              mem_wdata <= rx_byte;
              ptr       <= ptr + 1'b1;
            end
            PH_STAT_RD: tx_buf <= stat_byte;
            PH_STAT_WR: phase <= PH_SKIP;
            default: ;
          endcase
        end
        if (bit_fall && (phase == PH_RDATA || phase == PH_STAT_RD))
          miso_q <= tx_buf[~bit_cnt];
      end
    end
  end
endmodule

// File: rtl/spi_fram_slave.sv
module spi_fram_slave #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_clk,
  input  logic          spi_sel_n,
  input  logic          spi_mosi,
  input  logic          lock_pin_n,
  input  logic          pause_n,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata
);
  logic       bit_rise, bit_fall, sel_start, sel_end, held;
  logic       arm, guard, stat_ok, arm_set, arm_clr, stat_wr, new_guard, byte_done;
  logic [1:0] lvl, new_lvl;
  logic [7:0] stat_byte;
  logic [2:0] bit_cnt;

  spi_fram_pins u_pins (
    .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
    .pause_n(pause_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
    .sel_start(sel_start), .sel_end(sel_end), .held(held)
  );

  spi_fram_status u_status (
    .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .arm_clr(arm_clr),
    .stat_wr(stat_wr), .new_guard(new_guard), .new_lvl(new_lvl),
    .lock_pin_n(lock_pin_n), .arm(arm), .guard(guard), .lvl(lvl),
    .stat_ok(stat_ok), .stat_byte(stat_byte)
  );

  spi_fram_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
    .sel_start(sel_start), .sel_end(sel_end), .spi_mosi(spi_mosi),
    .arm(arm), .lvl(lvl), .stat_byte(stat_byte), .mem_rdata(mem_rdata),
    .miso_q(spi_miso), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .arm_set(arm_set), .arm_clr(arm_clr),
    .stat_wr(stat_wr), .new_guard(new_guard), .new_lvl(new_lvl),
    .byte_done(byte_done), .bit_cnt(bit_cnt)
  );

  assign spi_miso_oe = !spi_sel_n && pause_n;
endmodule

// File: rtl/spi_fram_checks.sv
module spi_fram_checks #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_sel_n,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    lvl,
  input logic          guard,
  input logic          arm,
  input logic          stat_wr,
  input logic          stat_ok,
  input logic          held,
  input logic [2:0]    bit_cnt
);
  import spi_fram_pkg::*;

  a_r6_write_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(arm));

  a_r7_no_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !region_locked(lvl, mem_addr[AW-1:AW-2]));

  a_r9_refused_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_ok) |=> ($stable(lvl) && $stable(guard)));

  a_r6_arm_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arm) |-> $past(spi_sel_n));

  a_r10_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !spi_sel_n) |=> $stable(bit_cnt));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

bind spi_fram_slave spi_fram_checks #(.AW(AW)) u_checks (
  .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .mem_we(mem_we),
  .mem_re(mem_re), .mem_addr(mem_addr), .lvl(lvl), .guard(guard), .arm(arm),
  .stat_wr(stat_wr), .stat_ok(stat_ok), .held(held), .bit_cnt(bit_cnt)
);

// File: tb/tb_spi_fram_slave.sv
module tb_spi_fram_slave;
  localparam int AW   = 11;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_clk = 1'b0, spi_sel_n = 1'b1, spi_mosi = 1'b0;
  logic lock_pin_n = 1'b1, pause_n = 1'b1;
  logic spi_miso, spi_miso_oe, mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] arr    [0:2047];
  logic [7:0] shadow [0:2047];
  logic       m_arm = 0, m_guard = 0;
  logic [1:0] m_lvl = 0;

  logic [7:0]    exp_v[$];  string exp_t[$];  logic [7:0] got_v[$];
  logic [AW-1:0] ew_a[$];   logic [7:0] ew_d[$]; string ew_t[$];

  always #2 clk = ~clk;

  spi_fram_slave #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
    .spi_mosi(spi_mosi), .lock_pin_n(lock_pin_n), .pause_n(pause_n),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] seed_val(int i);
    return 8'((i * 7 + 3) ^ (i >> 8));
  endfunction

  // array model: read data one clk after the strobe
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) arr[i] <= seed_val(i);
      mem_rdata <= '0;
    end else begin
      if (mem_we) arr[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= arr[mem_addr];
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: read bytes
  always @(negedge clk) begin
    while (got_v.size() > 0) begin
      if (exp_v.size() == 0) begin
        chk("R3 unexpected read byte", 32'(got_v.pop_front()), 32'hFFFF_FFFF);
      end else begin
        string t = exp_t.pop_front();
        chk(t, 32'(got_v.pop_front()), 32'(exp_v.pop_front()));
      end
    end
  end

  // monitor: write strobes
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (ew_a.size() == 0) begin
        chk("R7 unexpected write", {mem_addr, mem_wdata}, 32'hFFFF_FFFF);
      end else begin
        string t = ew_t.pop_front();
        chk(t, {mem_addr, mem_wdata}, {ew_a.pop_front(), ew_d.pop_front()});
      end
    end
  end

  function automatic logic locked(int a, logic [1:0] l);
    return (l == 2'd3) || (l == 2'd2 && a >= 1024) || (l == 2'd1 && a >= 1536);
  endfunction

  task automatic wclk(int n); repeat (n) @(negedge clk); endtask

  task automatic spi_bit(input logic b, output logic r);
    spi_mosi = b; wclk(HALF); r = spi_miso;
    spi_clk = 1'b1; wclk(HALF); spi_clk = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(t[i], r[i]);
  endtask

  task automatic sel_lo; spi_sel_n = 1'b0; wclk(HALF); endtask
  task automatic sel_hi; wclk(HALF); spi_sel_n = 1'b1; wclk(HALF); endtask

  task automatic op(logic [7:0] code);
    logic [7:0] r;
    sel_lo; spi_byte(code, r); sel_hi;
    if (code == 8'h06) m_arm = 1;
    if (code == 8'h04) m_arm = 0;
  endtask

  task automatic stat_rd(string tag, int n);
    logic [7:0] r;
    sel_lo; spi_byte(8'h05, r);
    for (int k = 0; k < n; k++) begin
      spi_byte(8'h00, r);
      exp_v.push_back({m_guard, 3'b000, m_lvl, m_arm, 1'b0}); exp_t.push_back(tag);
      got_v.push_back(r);
    end
    sel_hi;
  endtask

  task automatic stat_wr(logic [7:0] v);
    logic [7:0] r;
    sel_lo; spi_byte(8'h01, r); spi_byte(v, r); sel_hi;
    if (m_arm && !(m_guard && !lock_pin_n)) begin m_guard = v[7]; m_lvl = v[3:2]; end
    m_arm = 0;
  endtask

  task automatic wr_mem(logic [15:0] a, int n, logic [7:0] seed, string tag);
    logic [7:0] r, d;
    int p = int'(a[10:0]);
    sel_lo; spi_byte(8'h02, r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 13);
      if (m_arm && !locked(p, m_lvl)) begin
        ew_a.push_back(AW'(p)); ew_d.push_back(d); ew_t.push_back(tag);
        shadow[p] = d;
      end
      spi_byte(d, r);
      p = (p + 1) % 2048;
    end
    sel_hi; m_arm = 0;
  endtask

  task automatic rd_mem(logic [15:0] a, int n, string tag);
    logic [7:0] r;
    int p = int'(a[10:0]);
    sel_lo; spi_byte(8'h03, r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
    for (int k = 0; k < n; k++) begin
      spi_byte(8'hA5 ^ 8'(k), r);   // R11: noise on mosi during read data
      exp_v.push_back(shadow[p]); exp_t.push_back(tag);
      got_v.push_back(r);
      p = (p + 1) % 2048;
    end
    sel_hi;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic       b;
    for (int i = 0; i < 2048; i++) shadow[i] = seed_val(i);
    wclk(5); rst_n = 1'b1; wclk(5);
    chk("R1 reset oe", 32'(spi_miso_oe), 0);
    chk("R1 reset strobes", {mem_we, mem_re}, 0);

    stat_rd("R8 status after reset", 2);
    wr_mem(16'h0010, 2, 8'h30, "R6 unarmed write");
    rd_mem(16'h0010, 2, "R3 read untouched");
    op(8'h06); stat_rd("R6 arm visible", 1);
    wr_mem(16'hFFFE, 4, 8'h11, "R4 write wraps");
    stat_rd("R6 arm cleared by write end", 1);
    rd_mem(16'hF7FE, 4, "R2 read msb first wraps");

    op(8'h06); stat_wr(8'h84); stat_rd("R8 status layout", 1);
    op(8'h06); wr_mem(16'h05FF, 2, 8'h40, "R7 upper quarter");
    rd_mem(16'h05FF, 2, "R7 upper quarter readback");

    lock_pin_n = 1'b0; op(8'h06); stat_wr(8'h00); stat_rd("R9 frozen by pin", 1);
    lock_pin_n = 1'b1; op(8'h06); stat_wr(8'h08); stat_rd("R9 pin released", 1);
    op(8'h06); wr_mem(16'h03FF, 2, 8'h55, "R7 upper half");
    rd_mem(16'h03FF, 2, "R7 upper half readback");
    lock_pin_n = 1'b0; op(8'h06); stat_wr(8'h0C); stat_rd("R9 pin ignored", 1);
    op(8'h06); wr_mem(16'h0000, 3, 8'h66, "R7 whole array");
    rd_mem(16'h0000, 3, "R7 whole array readback");
    op(8'h06); stat_wr(8'h00); lock_pin_n = 1'b1; stat_rd("R8 cleared", 1);

    sel_lo; spi_byte(8'hAB, r); spi_byte(8'h06, r); sel_hi;
    stat_rd("R11 unknown code", 1);
    op(8'h06); op(8'h04); stat_rd("R6 disarm", 1);

    op(8'h06); wr_mem(16'h0200, 20, 8'h01, "R5 long write");
    rd_mem(16'h0200, 20, "R5 long readback");

    // R10: pause in the middle of a data byte
    op(8'h06);
    sel_lo; spi_byte(8'h02, r); spi_byte(8'h01, r); spi_byte(8'h00, r);
    ew_a.push_back(AW'(11'h100)); ew_d.push_back(8'hC3); ew_t.push_back("R10 paused write");
    shadow[11'h100] = 8'hC3;
    for (int i = 7; i >= 4; i--) spi_bit(1'(8'hC3 >> i), b);
    chk("R1 oe while selected", 32'(spi_miso_oe), 1);
    wclk(2); pause_n = 1'b0; wclk(HALF);
    chk("R10 oe off in pause", 32'(spi_miso_oe), 0);
    for (int k = 0; k < 5; k++) begin
      spi_mosi = k[0]; spi_clk = 1'b1; wclk(HALF); spi_clk = 1'b0; wclk(HALF);
    end
    pause_n = 1'b1; wclk(HALF);
    for (int i = 3; i >= 0; i--) spi_bit(1'(8'hC3 >> i), b);
    sel_hi; m_arm = 0;
    chk("R1 oe off after end", 32'(spi_miso_oe), 0);
    rd_mem(16'h0100, 1, "R10 paused readback");

    wclk(10);
    chk("R5 write queue drained", ew_a.size(), 0);
    chk("R3 read queue drained", exp_v.size(), 0);
    finish_run();
  end
endmodule